// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog

This block is a bank of watchdog channels on a simple register bus. Each channel counts down a reload period. Each time the period runs out, the channel moves one step along an escalation ladder chosen by its mode. The first step flags a host interrupt, which acts as an early warning. The second step can send a pulse to a management processor. The third step fires a one-cycle reset pulse to the core. Software restarts the period by poking the channel. If the poke stops coming, the ladder runs to the reset.

The live count is 24 bits wide. It reloads from a 16-bit length placed in its upper bits, with the low 8 bits zero. It steps down once per prescaler period of 2^DIV_LOG2 clocks, which is 1024 clocks by default. An expiry happens on a prescaler tick that finds the count at zero. At that tick the count reloads and the stage advances, so one period after a reload is (length·256 + 1)·2^DIV_LOG2 clocks.

The per-channel pending bits are cleared by writing 1. The enable bits have separate set and clear registers. The host interrupt is the OR of pending AND enabled over all channels. The management and reset outputs are the OR of the per-channel pulses.

Top module: `stage_watchdog`

## Requirements
- R1: After synchronous reset, every register reads zero and host_irq, mgmt_irq, core_rst and bus_rvalid are low.
- R2: The control register of channel c is at byte address 8·c. It holds mode in bits [1:0], the second-stage interrupt enable in bit 2, the reload length in bits [19:4] and the live count in bits [43:20]. The count field and all other bits ignore writes. A read returns its data with bus_rvalid one cycle after the request.
- R3: While mode is nonzero, the count drops by one once every 2^DIV_LOG2 clocks. While mode is 0, the count holds its value.
- R4: Writing a word with bit 0 set to address 0x10000 + 8·c loads the count with length·256. The same write clears the prescaler and returns the channel to stage one, in any mode.
- R5: After a poke, the first expiry comes exactly (length·256 + 1)·2^DIV_LOG2 clocks later. It sets the channel's pending bit whether or not the channel is enabled.
- R6: In mode 1, every expiry sets the pending bit, and no management or reset pulse is ever produced.
- R7: In mode 3, the expiries run in order: pending bit, then a one-cycle mgmt_irq pulse, then a one-cycle core_rst pulse. After that the channel returns to stage one. Only the first expiry sets pending.
- R8: In mode 3 with the second-stage enable at 0, the second expiry produces no output, and the third expiry still pulses core_rst.
- R9: The pending register is at 0x200, with bit c for channel c. Writing 1 to a bit clears it, and 0 bits have no effect. An expiry in the same cycle as the write wins over the clear.
- R10: Writing 1s to 0x218 sets enable bits, and writing 1s to 0x210 clears them. 0 bits are ignored in both, and both addresses read the enable bits. host_irq is high exactly when some channel is both pending and enabled.
- R11: In mode 2, the first expiry sets pending and the second pulses mgmt_irq if enabled. The channel then returns to stage one, and core_rst never pulses.
- R12: Writing mode 0 clears the stage and the prescaler. A later nonzero mode resumes from the held count, with its first tick a full prescaler period after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| host_irq | output | 1 | OR of pending AND enabled over channels |
| mgmt_irq | output | 1 | One-cycle pulse on an enabled second-stage expiry |
| core_rst | output | 1 | One-cycle pulse on a third-stage expiry |

## Verification
The bench builds the block with two channels and DIV_LOG2 = 2, so one prescaler tick is 4 clocks. A length of 1 then gives an expiry period of 1028 clocks. This makes the full three-stage ladder in every mode, and the exact cycle of each expiry edge, reachable within a short run. Two channels exercise the per-bit masking in the pending and enable registers, and allow a second channel to be counting while the first is idle.

// File: rtl/wdt_pkg.sv
// Shared types and register layout for the escalating watchdog.
// Assumes a 64-bit data bus and byte addressing with 8-byte register stride.
package wdt_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_IRQ  = 2'd1,
        MODE_TWO  = 2'd2,
        MODE_FULL = 2'd3
    } wdt_mode_e;

    typedef enum logic [1:0] {
        STG_ONE   = 2'd0,
        STG_TWO   = 2'd1,
        STG_THREE = 2'd2
    } wdt_stage_e;

    localparam int DATA_W      = 64;
    localparam int MODE_LSB    = 0;
    localparam int SECEN_BIT   = 2;
    localparam int LEN_LSB     = 4;
    localparam int LEN_W       = 16;
    localparam int LOW_W       = 8;
    localparam int CNT_LSB     = 20;
    localparam int CNT_W       = LEN_W + LOW_W;

    localparam int CTRL_STRIDE = 8;
    localparam int PEND_OFF    = 'h200;
    localparam int ENCLR_OFF   = 'h210;
    localparam int ENSET_OFF   = 'h218;
    localparam int POKE_BASE   = 'h10000;

endpackage

// File: rtl/wdt_prescaler.sv
// Free-running divider that emits one tick every 2**DIV_LOG2 clocks while run is high.
// Assumes clear has priority and holds the divider at zero.
module wdt_prescaler #(
    parameter int DIV_LOG2 = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);

    logic [DIV_LOG2-1:0] div_q;

    // Tick fires in the last clock of each divider period.
    assign tick = run && (div_q == {DIV_LOG2{1'b1}});

    // Divider state: cleared, advanced while running, else held.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_channel.sv
// One watchdog channel: reload counter, escalation stage and event generation.
// Assumes poke and mode changes never arrive in the same cycle (single bus).
module wdt_channel import wdt_pkg::*; #(
    parameter int DIV_LOG2  = 10,
    parameter int LEN_WIDTH = LEN_W,
    parameter int ZERO_BITS = LOW_W,
    localparam int CW       = LEN_WIDTH + ZERO_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  wdt_mode_e            mode,
    input  logic                 sec_en,
    input  logic [LEN_WIDTH-1:0] len,
    input  logic                 poke,
    output logic [CW-1:0]        count,
    output logic                 host_evt,
    output logic                 mgmt_pulse,
    output logic                 rst_pulse
);

    logic            tick;
    logic            expire;
    logic            running;
    logic [CW-1:0]   reload_val;
    logic [CW-1:0]   count_q;
    wdt_stage_e      stage_q;
    wdt_stage_e      stage_nx;

    assign running    = (mode != MODE_OFF);
    assign reload_val = {len, {ZERO_BITS{1'b0}}};
    assign expire     = tick && (count_q == '0);
    assign count      = count_q;

    wdt_prescaler #(.DIV_LOG2(DIV_LOG2)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poke || !running),
        .run   (running),
        .tick  (tick)
    );

    // Next stage after an expiry, chosen by the mode ladder.
    always_comb begin
        stage_nx = STG_ONE;
        unique case (mode)
            MODE_TWO:  stage_nx = (stage_q == STG_ONE) ? STG_TWO : STG_ONE;
            MODE_FULL: begin
                unique case (stage_q)
                    STG_ONE: stage_nx = STG_TWO;
                    STG_TWO: stage_nx = STG_THREE;
                    default: stage_nx = STG_ONE;
                endcase
            end
            default:   stage_nx = STG_ONE;
        endcase
    end

    // Counter and stage: poke reloads, mode off parks, tick counts or escalates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            stage_q <= STG_ONE;
        end else if (poke) begin
            count_q <= reload_val;
            stage_q <= STG_ONE;
        end else if (!running) begin
            stage_q <= STG_ONE;
        end else if (tick) begin
            if (count_q == '0) begin
                count_q <= reload_val;
                stage_q <= stage_nx;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    // Host event: first-stage expiry, or any expiry in interrupt-only mode.
    assign host_evt = expire && ((mode == MODE_IRQ) || (stage_q == STG_ONE));

    // Registered one-cycle pulses for the later stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mgmt_pulse <= 1'b0;
            rst_pulse  <= 1'b0;
        end else begin
            mgmt_pulse <= expire && (stage_q == STG_TWO) && sec_en &&
                          ((mode == MODE_TWO) || (mode == MODE_FULL));
            rst_pulse  <= expire && (stage_q == STG_THREE) && (mode == MODE_FULL);
        end
    end

endmodule

// File: rtl/wdt_regs.sv
// Register file and bus decode: per-channel control, poke strobes, pending and enable.
// Assumes NUM_CH <= 64 so control registers stay below the pending register.
module wdt_regs import wdt_pkg::*; #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 17,
    localparam int CW    = CNT_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_en,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic                           bus_rvalid,
    input  logic [NUM_CH-1:0]              host_evt,
    input  logic [NUM_CH-1:0][CW-1:0]      ch_count,
    output logic [NUM_CH-1:0][1:0]         ch_mode,
    output logic [NUM_CH-1:0]              ch_sec,
    output logic [NUM_CH-1:0][LEN_W-1:0]   ch_len,
    output logic [NUM_CH-1:0]              ch_poke,
    output logic [NUM_CH-1:0]              pend,
    output logic [NUM_CH-1:0]              enab
);

    logic                 wr;
    logic                 rd;
    logic [NUM_CH-1:0]    ctrl_hit;
    logic                 pend_hit;
    logic                 set_hit;
    logic                 clr_hit;
    logic [DATA_W-1:0]    rd_next;
    logic                 unused_wdata;

    assign wr           = bus_en && bus_we;
    assign rd           = bus_en && !bus_we;
    assign pend_hit     = (bus_addr == ADDR_W'(PEND_OFF));
    assign set_hit      = (bus_addr == ADDR_W'(ENSET_OFF));
    assign clr_hit      = (bus_addr == ADDR_W'(ENCLR_OFF));
    assign unused_wdata = ^bus_wdata;

    // Per-channel address matches and poke strobes.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        assign ctrl_hit[c] = (bus_addr == ADDR_W'(c * CTRL_STRIDE));
        assign ch_poke[c]  = wr && bus_wdata[0] &&
                             (bus_addr == ADDR_W'(POKE_BASE + c * CTRL_STRIDE));
    end

    // Control fields: written as a whole word, count bits discarded.
    always_ff @(posedge clk) begin
        for (int c = 0; c < NUM_CH; c++) begin
            if (!rst_n) begin
                ch_mode[c] <= 2'b00;
                ch_sec[c]  <= 1'b0;
                ch_len[c]  <= '0;
            end else if (wr && ctrl_hit[c]) begin
                ch_mode[c] <= bus_wdata[MODE_LSB +: 2];
                ch_sec[c]  <= bus_wdata[SECEN_BIT];
                ch_len[c]  <= bus_wdata[LEN_LSB +: LEN_W];
            end
        end
    end

    // Pending bits: expiry sets, write-1 clears, set wins.
    always_ff @(posedge clk) begin
        for (int c = 0; c < NUM_CH; c++) begin
            if (!rst_n) begin
                pend[c] <= 1'b0;
            end else if (host_evt[c]) begin
                pend[c] <= 1'b1;
            end else if (wr && pend_hit && bus_wdata[c]) begin
                pend[c] <= 1'b0;
            end
        end
    end

    // Enable bits: separate set and clear addresses, zero bits ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enab <= '0;
        end else if (wr && set_hit) begin
            enab <= enab | bus_wdata[NUM_CH-1:0];
        end else if (wr && clr_hit) begin
            enab <= enab & ~bus_wdata[NUM_CH-1:0];
        end
    end

    // Read multiplexer over all readable registers.
    always_comb begin
        rd_next = '0;
        if (pend_hit) begin
            rd_next[NUM_CH-1:0] = pend;
        end else if (set_hit || clr_hit) begin
            rd_next[NUM_CH-1:0] = enab;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (ctrl_hit[c]) begin
                    rd_next[MODE_LSB +: 2]    = ch_mode[c];
                    rd_next[SECEN_BIT]        = ch_sec[c];
                    rd_next[LEN_LSB +: LEN_W] = ch_len[c];
                    rd_next[CNT_LSB +: CW]    = ch_count[c];
                end
            end
        end
    end

    // Registered read response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd;
            if (rd) begin
                bus_rdata <= rd_next;
            end
        end
    end

endmodule

// File: rtl/stage_watchdog.sv
// Top of the escalating watchdog bank: register file plus NUM_CH channels.
// Assumes synchronous active-low reset and one bus access per cycle.
module stage_watchdog import wdt_pkg::*; #(
    parameter int NUM_CH   = 4,
    parameter int DIV_LOG2 = 10,
    parameter int ADDR_W   = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              host_irq,
    output logic              mgmt_irq,
    output logic              core_rst
);

    localparam int CW = CNT_W;

    logic [NUM_CH-1:0][1:0]       ch_mode;
    logic [NUM_CH-1:0]            ch_sec;
    logic [NUM_CH-1:0][LEN_W-1:0] ch_len;
    logic [NUM_CH-1:0]            ch_poke;
    logic [NUM_CH-1:0][CW-1:0]    ch_count;
    logic [NUM_CH-1:0]            host_evt;
    logic [NUM_CH-1:0]            ch_mgmt;
    logic [NUM_CH-1:0]            ch_rst;
    logic [NUM_CH-1:0]            pend_vec;
    logic [NUM_CH-1:0]            en_vec;

    wdt_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .host_evt   (host_evt),
        .ch_count   (ch_count),
        .ch_mode    (ch_mode),
        .ch_sec     (ch_sec),
        .ch_len     (ch_len),
        .ch_poke    (ch_poke),
        .pend       (pend_vec),
        .enab       (en_vec)
    );

    // One counter/escalation engine per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        wdt_channel #(.DIV_LOG2(DIV_LOG2)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode       (wdt_mode_e'(ch_mode[c])),
            .sec_en     (ch_sec[c]),
            .len        (ch_len[c]),
            .poke       (ch_poke[c]),
            .count      (ch_count[c]),
            .host_evt   (host_evt[c]),
            .mgmt_pulse (ch_mgmt[c]),
            .rst_pulse  (ch_rst[c])
        );
    end

    assign host_irq = |(pend_vec & en_vec);
    assign mgmt_irq = |ch_mgmt;
    assign core_rst = |ch_rst;

endmodule

// File: rtl/wdt_checker.sv
// Property checker for the escalating watchdog, attached to the top by bind.
// Assumes it observes the top's internal per-channel vectors.
module wdt_checker #(
    parameter int NUM_CH    = 4,
    parameter int LEN_WIDTH = 16,
    parameter int ZERO_BITS = 8,
    localparam int CW       = LEN_WIDTH + ZERO_BITS
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_CH-1:0][1:0]          ch_mode,
    input logic [NUM_CH-1:0][LEN_WIDTH-1:0] ch_len,
    input logic [NUM_CH-1:0][CW-1:0]       ch_count,
    input logic [NUM_CH-1:0]               ch_poke,
    input logic [NUM_CH-1:0]               ch_rst,
    input logic [NUM_CH-1:0]               host_evt,
    input logic [NUM_CH-1:0]               pend_vec
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk

        a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
            ch_poke[c] |=> (ch_count[c] == (CW'($past(ch_len[c])) << ZERO_BITS)));

        a_r3_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_mode[c] == 2'b00 && !ch_poke[c]) |=> $stable(ch_count[c]));

        a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_mode[c] != 2'b00 && !ch_poke[c] && ch_count[c] != '0) |=>
            (ch_count[c] == $past(ch_count[c]) ||
             ch_count[c] == CW'($past(ch_count[c]) - 1'b1)));

        a_r7_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
            ch_rst[c] |=> !ch_rst[c]);

        a_r9_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_vec[c]) |-> $past(host_evt[c]));
    end

endmodule

bind stage_watchdog wdt_checker #(
    .NUM_CH    (NUM_CH),
    .LEN_WIDTH (wdt_pkg::LEN_W),
    .ZERO_BITS (wdt_pkg::LOW_W)
) u_wdt_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_mode  (ch_mode),
    .ch_len   (ch_len),
    .ch_count (ch_count),
    .ch_poke  (ch_poke),
    .ch_rst   (ch_rst),
    .host_evt (host_evt),
    .pend_vec (pend_vec)
);

// File: tb/stage_watchdog_test.sv
`timescale 1ns/1ps
module stage_watchdog_test;

    localparam int NCH   = 2;
    localparam int DIVL  = 2;
    localparam int TICKP = 4;
    localparam int AW    = 17;
    localparam int LEN1  = 1;
    localparam int RLD1  = 256;
    localparam int PER   = (RLD1 + 1) * TICKP;

    localparam logic [AW-1:0] A_CTRL0 = 17'h0;
    localparam logic [AW-1:0] A_CTRL1 = 17'h8;
    localparam logic [AW-1:0] A_PEND  = 17'h200;
    localparam logic [AW-1:0] A_ECLR  = 17'h210;
    localparam logic [AW-1:0] A_ESET  = 17'h218;
    localparam logic [AW-1:0] A_POKE0 = 17'h10000;
    localparam logic [AW-1:0] A_POKE1 = 17'h10008;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [63:0]   bus_wdata = '0;
    logic [63:0]   bus_rdata;
    logic          bus_rvalid;
    logic          host_irq;
    logic          mgmt_irq;
    logic          core_rst;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    stage_watchdog #(.NUM_CH(NCH), .DIV_LOG2(DIVL), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .host_irq(host_irq), .mgmt_irq(mgmt_irq),
        .core_rst(core_rst)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] ctrl_word(input int mode, input int sec, input int len);
        return (64'(len & 16'hFFFF) << 4) | (64'(sec & 1) << 2) | 64'(mode & 3);
    endfunction

    function automatic int count_at(input int rld, input int poke_edge, input int samp_edge);
        return rld - (samp_edge - 1 - poke_edge) / TICKP;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_to(input int t);
        if (cyc > t) chk(1'b0, "TIMING late sample", 64'(cyc), 64'(t));
        while (cyc < t) @(negedge clk);
    endtask

    task automatic start_ch0(input int mode, input int sec, output int edge_o);
        wr(A_CTRL0, ctrl_word(0, 0, LEN1));
        wr(A_PEND, 64'h3);
        wr(A_CTRL0, ctrl_word(mode, sec, LEN1));
        wr(A_POKE0, 64'h1);
        edge_o = cyc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [63:0] d2;
        logic [1:0]  en_model;
        int e;
        int w;
        int c_held;
        int seed;
        seed = $urandom(32'd20240611);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!host_irq && !mgmt_irq && !core_rst && !bus_rvalid, "R1 outputs", 64'({host_irq, mgmt_irq, core_rst, bus_rvalid}), 64'h0);
        rd(A_CTRL0, d); chk(d == 64'h0, "R1 ctrl0", d, 64'h0);
        rd(A_CTRL1, d); chk(d == 64'h0, "R1 ctrl1", d, 64'h0);
        rd(A_PEND, d);  chk(d == 64'h0, "R1 pend", d, 64'h0);
        rd(A_ESET, d);  chk(d == 64'h0, "R1 enable", d, 64'h0);

        // R2 random control writes with mode 0; count bits in wdata ignored
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] a;
            int len, sec;
            logic [63:0] junk;
            a    = ($urandom_range(0, 1) == 0) ? A_CTRL0 : A_CTRL1;
            len  = $urandom_range(0, 16'hFFFF);
            sec  = $urandom_range(0, 1);
            junk = {$urandom(), $urandom()} & 64'hFFFF_FFFF_FFF0_0008;
            wr(a, ctrl_word(0, sec, len) | junk);
            rd(a, d);
            chk(d == ctrl_word(0, sec, len), "R2 control readback", d, ctrl_word(0, sec, len));
            chk(bus_rvalid, "R2 read valid", 64'(bus_rvalid), 64'h1);
        end

        // R10 random enable set/clear against a bench model
        en_model = 2'b00;
        for (int i = 0; i < 10; i++) begin
            logic [63:0] m;
            m = {$urandom(), $urandom()};
            if ($urandom_range(0, 1) == 1) begin
                wr(A_ESET, m); en_model = en_model | m[1:0];
            end else begin
                wr(A_ECLR, m); en_model = en_model & ~m[1:0];
            end
            rd((i % 2 == 0) ? A_ESET : A_ECLR, d);
            chk(d == 64'(en_model), "R10 enable model", d, 64'(en_model));
        end
        wr(A_ECLR, 64'h3);
        wr(A_ESET, 64'h1);

        // R4 poke in mode 0 loads length*256
        wr(A_CTRL0, ctrl_word(0, 0, 16'h00A5));
        wr(A_POKE0, 64'h1);
        rd(A_CTRL0, d);
        chk(d[43:20] == 24'hA500, "R4 reload value", 64'(d[43:20]), 64'hA500);

        // R3 count steps once per prescaler period on channel 1
        wr(A_CTRL1, ctrl_word(1, 0, 2));
        wr(A_POKE1, 64'h1);
        e = cyc;
        for (int i = 0; i < 6; i++) begin
            int exp_c;
            repeat ($urandom_range(1, 40)) @(negedge clk);
            rd(A_CTRL1, d);
            exp_c = count_at(512, e, cyc);
            chk(d[43:20] == 24'(exp_c), "R3 count step", 64'(d[43:20]), 64'(exp_c));
        end
        wr(A_CTRL1, ctrl_word(0, 0, 2));
        wr(A_PEND, 64'h3);
        chk(!host_irq, "R10 host low with ch1 masked", 64'(host_irq), 64'h0);

        // R7 full ladder with second stage enabled; R5 timing; R9 clear
        start_ch0(3, 1, e);
        wait_to(e + PER - 1); chk(!host_irq, "R5 before first expiry", 64'(host_irq), 64'h0);
        wait_to(e + PER);     chk(host_irq, "R5 first expiry", 64'(host_irq), 64'h1);
        wr(A_PEND, 64'h0);    chk(host_irq, "R9 zero write ignored", 64'(host_irq), 64'h1);
        wr(A_PEND, 64'h1);    chk(!host_irq, "R9 write one clears", 64'(host_irq), 64'h0);
        wait_to(e + 2*PER - 1); chk(!mgmt_irq, "R7 mgmt before", 64'(mgmt_irq), 64'h0);
        wait_to(e + 2*PER);   chk(mgmt_irq, "R7 mgmt pulse", 64'(mgmt_irq), 64'h1);
        chk(!host_irq, "R7 second expiry no pending", 64'(host_irq), 64'h0);
        wait_to(e + 2*PER + 1); chk(!mgmt_irq, "R7 mgmt one cycle", 64'(mgmt_irq), 64'h0);
        wait_to(e + 3*PER - 1); chk(!core_rst, "R7 reset before", 64'(core_rst), 64'h0);
        wait_to(e + 3*PER);   chk(core_rst, "R7 reset pulse", 64'(core_rst), 64'h1);
        wait_to(e + 3*PER + 1); chk(!core_rst, "R7 reset one cycle", 64'(core_rst), 64'h0);
        wait_to(e + 4*PER);   chk(host_irq, "R7 back to stage one", 64'(host_irq), 64'h1);

        // R8 second stage disabled: silent second, reset on third
        start_ch0(3, 0, e);
        wait_to(e + PER);     chk(host_irq, "R8 first expiry", 64'(host_irq), 64'h1);
        wr(A_PEND, 64'h1);
        wait_to(e + 2*PER);   chk(!mgmt_irq && !host_irq, "R8 silent second", 64'({mgmt_irq, host_irq}), 64'h0);
        wait_to(e + 3*PER);   chk(core_rst, "R8 reset on third", 64'(core_rst), 64'h1);

        // R6 interrupt-only mode: pending on every expiry, no reset
        start_ch0(1, 1, e);
        wait_to(e + PER);     chk(host_irq, "R6 first", 64'(host_irq), 64'h1);
        wr(A_PEND, 64'h1);
        wait_to(e + 2*PER);   chk(host_irq && !mgmt_irq, "R6 second", 64'({host_irq, mgmt_irq}), 64'h2);
        wr(A_PEND, 64'h1);
        wait_to(e + 3*PER);   chk(host_irq && !core_rst, "R6 third", 64'({host_irq, core_rst}), 64'h2);

        // R11 two-interrupt mode; R4 poke returns stage to one
        start_ch0(2, 1, e);
        wait_to(e + PER);     chk(host_irq, "R11 first", 64'(host_irq), 64'h1);
        wr(A_PEND, 64'h1);
        wr(A_POKE0, 64'h1);
        w = cyc;
        wait_to(w + PER);     chk(host_irq && !mgmt_irq, "R4 poke resets stage", 64'({host_irq, mgmt_irq}), 64'h2);
        wr(A_PEND, 64'h1);
        wait_to(w + 2*PER);   chk(mgmt_irq, "R11 mgmt on second", 64'(mgmt_irq), 64'h1);
        wait_to(w + 3*PER);   chk(host_irq && !core_rst, "R11 wraps, no reset", 64'({host_irq, core_rst}), 64'h2);

        // R12 mode 0 clears stage and prescaler, count resumes from held value
        start_ch0(3, 1, e);
        wait_to(e + PER);     chk(host_irq, "R12 first expiry", 64'(host_irq), 64'h1);
        wr(A_PEND, 64'h1);
        wr(A_CTRL0, ctrl_word(0, 1, LEN1));
        rd(A_CTRL0, d);
        repeat (20) @(negedge clk);
        rd(A_CTRL0, d2);
        chk(d2[43:20] == d[43:20], "R3 count held in mode 0", 64'(d2[43:20]), 64'(d[43:20]));
        c_held = int'(d[43:20]);
        wr(A_CTRL0, ctrl_word(3, 1, LEN1));
        w = cyc;
        wait_to(w + (c_held + 1) * TICKP - 1); chk(!host_irq && !mgmt_irq, "R12 before resume expiry", 64'({host_irq, mgmt_irq}), 64'h0);
        wait_to(w + (c_held + 1) * TICKP);     chk(host_irq, "R12 stage one after mode 0", 64'(host_irq), 64'h1);
        wait_to(w + (c_held + 1) * TICKP + 1); chk(!mgmt_irq, "R12 no mgmt", 64'(mgmt_irq), 64'h0);

        wr(A_CTRL0, ctrl_word(0, 0, LEN1));
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule